// File: doc/BRIEF.md
# Double-Buffered SPI Port Controller

This block is an 8-bit full-duplex SPI port that a processor drives through a small register bus. Bytes written to the transmit data register queue in a transmit FIFO. Every completed byte is placed in a receive FIFO. A read of the receive data register takes the oldest byte out of that FIFO. Software can therefore load the next byte while the current one is on the wire, and can collect an earlier byte while a new one is arriving.

In master role, the block generates the serial clock by dividing the system clock by a power of two. Clock polarity and phase are selectable. Chip select is either driven by a control bit or produced by the block around each transfer. In automatic mode, chip select stays low across back-to-back bytes for as long as the transmit FIFO keeps supplying data. In slave role, the block synchronises the external clock, data and select pins to the system clock. A control bit chooses whether the select input gates reception. A single interrupt line reports either a full receive FIFO or an empty transmit FIFO.

Top module: `spi_dbuf_ctrl`

## Requirements
- R1: After synchronous reset, the control, clock-divide and receive data registers read 0, the status register reads 0x50, ss_n_o is 1, sclk_o is 0 and irq is 0. The register addresses are 0 transmit data (write), 1 receive data (read), 2 control, 3 clock divide (bits 2:0) and 4 status. The control bits are: 0 enable, 1 master, 2 clock polarity, 3 clock phase, 4 interrupt source, 5 automatic select, 6 select bit.
- R2: In master role, each byte is shifted out MSB first on mosi_o while 8 bits are taken in from miso_i. The bits taken in become the received byte.
- R3: The transmit FIFO and the receive FIFO each hold 4 bytes and keep first-in first-out order.
- R4: With automatic select on, ss_n_o goes low for a lone byte and returns high after it. When the transmit FIFO is non-empty at the end of a byte, the next byte follows and ss_n_o stays low until the last byte has finished.
- R5: In master role with automatic select off, ss_n_o equals the select bit, so it is low while that bit is 0.
- R6: Idle sclk_o equals the polarity bit. With phase 0, data is sampled on the leading edge. With phase 1, data is sampled on the trailing edge. All four modes transfer correctly.
- R7: With clock-divide value k, one sclk_o period lasts 2^(k+1) system clocks.
- R8: irq is the transmit-FIFO-empty flag when the interrupt source bit is 1. It is the receive-FIFO-full flag when that bit is 0.
- R9: The status register bits are: 0 transmit overflow, 1 receive overflow, 2 receive underflow, 3 busy, 4 transmit empty, 5 transmit full, 6 receive empty, 7 receive full. A write to a full transmit FIFO, or a byte arriving while the receive FIFO is full, drops the byte and sets the matching sticky bit. Writing 1 to a sticky bit clears it.
- R10: A read of an empty receive FIFO returns the last byte read and sets the underflow bit.
- R11: In slave role with phase 0 and polarity 0, the block samples mosi_i on rising sclk_i edges. It drives the head of the transmit FIFO on miso_o, MSB first.
- R12: In slave role with the select bit set, sclk_i edges are ignored while ss_n_i is high. With the select bit clear, ss_n_i is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| irq | output | 1 | Interrupt request |
| sclk_o | output | 1 | Serial clock in master role |
| sclk_i | input | 1 | Serial clock in slave role |
| mosi_o | output | 1 | Serial data out in master role |
| mosi_i | input | 1 | Serial data in for slave role |
| miso_o | output | 1 | Serial data out in slave role |
| miso_i | input | 1 | Serial data in for master role |
| ss_n_o | output | 1 | Active-low select out in master role |
| ss_n_i | input | 1 | Active-low select in for slave role |

## Verification
A FIFO pointer or count that goes wrong shows up at the bus within a few reads. Bytes come back out of order, or a flag in status disagrees with the number of bytes written and read. A half-period counter or bit counter that goes wrong shows within one byte time as a wrong sclk_o period, a shifted byte on mosi_o, or a missing or extra rise of ss_n_o. Slave-side faults show up as a wrong byte in the receive FIFO or on miso_o at the end of the same transfer.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;
    localparam int HALF_W = $clog2(2 * BYTE_W);
    localparam int BIT_W  = $clog2(BYTE_W);

    localparam logic [ADDR_W-1:0] ADDR_TXDATA = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_RXDATA = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_CLKDIV = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd4;

    typedef struct packed {
        logic sel_ss;
        logic auto_ss;
        logic irq_on_tx;
        logic cpha;
        logic cpol;
        logic master;
        logic enable;
    } ctrl_t;

    typedef struct packed {
        logic rx_full;
        logic rx_empty;
        logic tx_full;
        logic tx_empty;
        logic busy;
        logic rx_udf;
        logic rx_ovf;
        logic tx_ovf;
    } status_t;

    // Half-period index being entered: odd values follow a leading edge.
    function automatic logic samp_at(input logic cpha, input logic [HALF_W:0] nxt);
        return cpha ? ~nxt[0] : nxt[0];
    endfunction

    function automatic logic shift_at(input logic cpha, input logic [HALF_W:0] nxt);
        if (cpha)
            return nxt[0] && (nxt > (HALF_W+1)'(1));
        return !nxt[0] && (nxt < (HALF_W+1)'(2 * BYTE_W));
    endfunction

endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)
                count <= count + 1'b1;
            else if (do_pop && !do_push)
                count <= count - 1'b1;
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    assert_pop_drains_R3: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && !empty) |=> (count == CNT_W'($past(count) - 1'b1)));

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_dbuf_pkg::*;
#(
    parameter int DIV_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [DIV_W-1:0]  div_exp,
    input  logic              tx_avail,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              busy,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic              ss_n_o,
    output logic              miso_o,
    input  logic              miso_i,
    input  logic              sclk_i,
    input  logic              mosi_i,
    input  logic              ss_n_i
);
    localparam int CNT_W = 1 << DIV_W;
    localparam logic [HALF_W-1:0] LAST_HALF = HALF_W'(2 * BYTE_W - 1);

    logic m_act, s_act;
    assign m_act = ctrl.enable && ctrl.master;
    assign s_act = ctrl.enable && !ctrl.master;

    // ---------------- master side ----------------
    logic              m_busy;
    logic [HALF_W-1:0] half;
    logic [CNT_W-1:0]  cnt, limit;
    logic [BYTE_W-1:0] tsh, rsh;
    logic [HALF_W:0]   nxt;
    logic              tick, last, m_start;

    assign limit   = (CNT_W'(1) << div_exp) - CNT_W'(1);
    assign tick    = m_busy && (cnt == limit);
    assign nxt     = {1'b0, half} + 1'b1;
    assign last    = tick && (half == LAST_HALF);
    assign m_start = m_act && !m_busy && tx_avail;

    always_ff @(posedge clk) begin
        if (rst || !m_act) begin
            m_busy <= 1'b0;
            half   <= '0;
            cnt    <= '0;
            tsh    <= '0;
            rsh    <= '0;
        end else if (m_start) begin
            m_busy <= 1'b1;
            half   <= '0;
            cnt    <= '0;
            tsh    <= tx_byte;
        end else if (tick) begin
            cnt <= '0;
            if (samp_at(ctrl.cpha, nxt))
                rsh <= {rsh[BYTE_W-2:0], miso_i};
            if (last) begin
                half <= '0;
                if (tx_avail) tsh <= tx_byte;
                else          m_busy <= 1'b0;
            end else begin
                half <= nxt[HALF_W-1:0];
                if (shift_at(ctrl.cpha, nxt))
                    tsh <= tsh << 1;
            end
        end else if (m_busy) begin
            cnt <= cnt + 1'b1;
        end
    end

    // ---------------- slave side ----------------
    logic [2:0]       sck_q;
    logic [1:0]       sdi_q, ssn_q;
    logic [BIT_W-1:0] s_cnt;
    logic             s_loaded;
    logic [BYTE_W-1:0] ssh, srx;
    logic             s_edge, s_lead, s_trail, s_sel;
    logic             s_samp, s_shift, s_load, s_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= '0;
            sdi_q <= '0;
            ssn_q <= '1;
        end else begin
            sck_q <= {sck_q[1:0], sclk_i};
            sdi_q <= {sdi_q[0], mosi_i};
            ssn_q <= {ssn_q[0], ss_n_i};
        end
    end

    assign s_edge  = sck_q[2] ^ sck_q[1];
    assign s_lead  = s_edge && (sck_q[1] != ctrl.cpol);
    assign s_trail = s_edge && (sck_q[1] == ctrl.cpol);
    assign s_sel   = !ctrl.sel_ss || !ssn_q[1];
    assign s_samp  = s_act && s_sel && (ctrl.cpha ? s_trail : s_lead);
    assign s_shift = s_act && s_sel && (ctrl.cpha ? s_lead : s_trail) && (s_cnt != '0);
    assign s_load  = s_act && !s_loaded && tx_avail && (s_cnt == '0) && !s_samp;
    assign s_last  = s_samp && (s_cnt == BIT_W'(BYTE_W - 1));

    always_ff @(posedge clk) begin
        if (rst || !s_act) begin
            s_cnt    <= '0;
            s_loaded <= 1'b0;
            ssh      <= '0;
            srx      <= '0;
        end else begin
            if (!s_sel)
                s_cnt <= '0;
            else if (s_samp) begin
                srx   <= {srx[BYTE_W-2:0], sdi_q[1]};
                s_cnt <= s_cnt + 1'b1;
            end
            if (s_load) begin
                ssh      <= tx_byte;
                s_loaded <= 1'b1;
            end else if (s_last) begin
                ssh      <= '0;
                s_loaded <= 1'b0;
            end else if (s_shift)
                ssh <= ssh << 1;
        end
    end

    // ---------------- outputs ----------------
    assign tx_pop  = m_start || (last && tx_avail) || s_load;
    assign rx_push = last || s_last;
    assign rx_byte = ctrl.master ? (ctrl.cpha ? {rsh[BYTE_W-2:0], miso_i} : rsh)
                                 : {srx[BYTE_W-2:0], sdi_q[1]};
    assign busy    = m_busy || (s_cnt != '0);
    assign sclk_o  = m_busy ? (ctrl.cpol ^ half[0]) : ctrl.cpol;
    assign mosi_o  = tsh[BYTE_W-1];
    assign ss_n_o  = !m_act || (ctrl.auto_ss ? !m_busy : ctrl.sel_ss);
    assign miso_o  = ssh[BYTE_W-1];

    logic unused_ctrl;
    assign unused_ctrl = ctrl.irq_on_tx;

    assert_half_step_R7: assert property (@(posedge clk) disable iff (rst)
        (m_act && tick && !last) |=> (m_busy && half == HALF_W'($past(half) + 1'b1)));

    assert_sclk_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (m_act && m_busy && !tick) |=> ($stable(sclk_o) || !m_act || !$stable(ctrl)));

    assert_slave_gate_R12: assert property (@(posedge clk) disable iff (rst)
        (s_act && !s_sel) |=> (s_cnt == '0));

    assert_auto_ss_R4: assert property (@(posedge clk) disable iff (rst)
        (m_act && ctrl.auto_ss && last && tx_avail) |=> (!ss_n_o || !m_act || !$stable(ctrl)));

endmodule

// File: rtl/spi_dbuf_ctrl.sv
module spi_dbuf_ctrl
    import spi_dbuf_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int DIV_W      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              irq,
    output logic              sclk_o,
    input  logic              sclk_i,
    output logic              mosi_o,
    input  logic              mosi_i,
    output logic              miso_o,
    input  logic              miso_i,
    output logic              ss_n_o,
    input  logic              ss_n_i
);
    ctrl_t             ctrl_q;
    logic [DIV_W-1:0]  div_q;
    logic              tx_ovf_q, rx_ovf_q, rx_udf_q;
    logic [BYTE_W-1:0] last_rx_q;
    logic [2:0]        clr;

    logic              tx_full, tx_empty, tx_pop, tx_wr;
    logic [BYTE_W-1:0] tx_head;
    logic              rx_full, rx_empty, rx_push, rx_rd;
    logic [BYTE_W-1:0] rx_head, rx_byte;
    logic              busy;
    status_t           status;

    assign tx_wr = bus_wr && (bus_addr == ADDR_TXDATA);
    assign rx_rd = bus_rd && (bus_addr == ADDR_RXDATA);
    assign clr   = (bus_wr && bus_addr == ADDR_STATUS) ? bus_wdata[2:0] : 3'b000;

    spi_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk(clk), .rst(rst),
        .push(tx_wr), .wdata(bus_wdata),
        .pop(tx_pop), .rdata(tx_head),
        .full(tx_full), .empty(tx_empty)
    );

    spi_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk(clk), .rst(rst),
        .push(rx_push), .wdata(rx_byte),
        .pop(rx_rd), .rdata(rx_head),
        .full(rx_full), .empty(rx_empty)
    );

    spi_shift_engine #(.DIV_W(DIV_W)) u_engine (
        .clk(clk), .rst(rst),
        .ctrl(ctrl_q), .div_exp(div_q),
        .tx_avail(!tx_empty), .tx_byte(tx_head), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_byte(rx_byte), .busy(busy),
        .sclk_o(sclk_o), .mosi_o(mosi_o), .ss_n_o(ss_n_o), .miso_o(miso_o),
        .miso_i(miso_i), .sclk_i(sclk_i), .mosi_i(mosi_i), .ss_n_i(ss_n_i)
    );

    always_comb begin
        status          = '0;
        status.rx_full  = rx_full;
        status.rx_empty = rx_empty;
        status.tx_full  = tx_full;
        status.tx_empty = tx_empty;
        status.busy     = busy;
        status.rx_udf   = rx_udf_q;
        status.rx_ovf   = rx_ovf_q;
        status.tx_ovf   = tx_ovf_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            div_q     <= '0;
            tx_ovf_q  <= 1'b0;
            rx_ovf_q  <= 1'b0;
            rx_udf_q  <= 1'b0;
            last_rx_q <= '0;
            bus_rdata <= '0;
        end else begin
            if (bus_wr && bus_addr == ADDR_CTRL)
                ctrl_q <= ctrl_t'(bus_wdata[6:0]);
            if (bus_wr && bus_addr == ADDR_CLKDIV)
                div_q <= bus_wdata[DIV_W-1:0];
            tx_ovf_q <= (tx_ovf_q && !clr[0]) || (tx_wr && tx_full);
            rx_ovf_q <= (rx_ovf_q && !clr[1]) || (rx_push && rx_full);
            rx_udf_q <= (rx_udf_q && !clr[2]) || (rx_rd && rx_empty);
            if (bus_rd) begin
                case (bus_addr)
                    ADDR_RXDATA: begin
                        if (!rx_empty) begin
                            bus_rdata <= rx_head;
                            last_rx_q <= rx_head;
                        end else
                            bus_rdata <= last_rx_q;
                    end
                    ADDR_CTRL:   bus_rdata <= {1'b0, ctrl_q};
                    ADDR_CLKDIV: bus_rdata <= BYTE_W'(div_q);
                    ADDR_STATUS: bus_rdata <= status;
                    default:     bus_rdata <= '0;
                endcase
            end
        end
    end

    assign irq = ctrl_q.irq_on_tx ? tx_empty : rx_full;

    logic unused_wdata;
    assign unused_wdata = bus_wdata[7];

    assert_tx_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (tx_ovf_q && !clr[0]) |=> tx_ovf_q);

    assert_rx_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_ovf_q && !clr[1]) |=> rx_ovf_q);

    assert_udf_keeps_data_R10: assert property (@(posedge clk) disable iff (rst)
        (rx_rd && rx_empty) |=> (bus_rdata == $past(last_rx_q) && rx_udf_q));

    assert_irq_source_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.irq_on_tx && tx_wr && !tx_pop) |=> !irq);

endmodule

// File: tb/test_spi_dbuf_ctrl.sv
module test_spi_dbuf_ctrl;
    localparam logic [2:0] A_TX = 3'd0, A_RX = 3'd1, A_CTRL = 3'd2, A_DIV = 3'd3, A_STAT = 3'd4;
    localparam logic [7:0] C_EN = 8'h01, C_MS = 8'h02, C_POL = 8'h04, C_PHA = 8'h08,
                           C_IRQTX = 8'h10, C_AUTO = 8'h20, C_SS = 8'h40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq, sclk_o, mosi_o, miso_o, ss_n_o, miso_i;
    logic       sclk_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    // monitor state
    bit         mon_on = 1'b0, mon_cpol = 1'b0, mon_cpha = 1'b0;
    logic [7:0] mon_sh = '0;
    int         mon_bits = 0, mon_n = 0;
    logic [7:0] mon_q [16];
    int         per_cnt = 0, per_last = 0, ss_rises = 0;
    logic       sclk_prev = 1'b0, ss_prev = 1'b1;

    assign miso_i = mosi_o;  // loopback for master-role tests

    always #5 clk = ~clk;

    spi_dbuf_ctrl i_spi_dbuf_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .sclk_o(sclk_o), .sclk_i(sclk_i), .mosi_o(mosi_o), .mosi_i(mosi_i),
        .miso_o(miso_o), .miso_i(miso_i), .ss_n_o(ss_n_o), .ss_n_i(ss_n_i)
    );

    always @(negedge clk) begin
        per_cnt++;
        if (sclk_o != sclk_prev) begin
            if (sclk_o) begin
                per_last = per_cnt;
                per_cnt  = 0;
            end
            if (mon_on && (((sclk_o != mon_cpol) ? 1'b1 : 1'b0) ^ mon_cpha)) begin
                mon_sh = {mon_sh[6:0], mosi_o};
                mon_bits++;
                if (mon_bits == 8) begin
                    if (mon_n < 16) mon_q[mon_n] = mon_sh;
                    mon_n++;
                    mon_bits = 0;
                end
            end
        end
        if (ss_n_o && !ss_prev) ss_rises++;
        sclk_prev = sclk_o;
        ss_prev   = ss_n_o;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 4000; i++) begin
            bus_read(A_STAT, s);
            if (!s[3] && s[4]) break;
        end
    endtask

    task automatic mon_arm(input bit pol, input bit pha);
        mon_on = 1'b0;
        mon_cpol = pol;
        mon_cpha = pha;
        repeat (2) @(negedge clk);
        mon_bits = 0;
        mon_n = 0;
        mon_on = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 ss_n_o", ss_n_o, 1);
        check("R1 sclk_o", sclk_o, 0);
        check("R1 irq", irq, 0);
        bus_read(A_CTRL, d);   check("R1 ctrl", d, 8'h00);
        bus_read(A_DIV, d);    check("R1 clkdiv", d, 8'h00);
        bus_read(A_STAT, d);   check("R1 status", d, 8'h50);
        bus_read(A_RX, d);     check("R1 rxdata", d, 8'h00);
        bus_write(A_STAT, 8'h07);
    endtask

    task automatic t_manual_ss();
        bus_write(A_CTRL, C_EN | C_MS);
        check("R5 select low", ss_n_o, 0);
        bus_write(A_CTRL, C_EN | C_MS | C_SS);
        check("R5 select high", ss_n_o, 1);
        bus_write(A_CTRL, 8'h00);
    endtask

    task automatic t_single_k0();
        logic [7:0] d;
        int r0;
        bus_write(A_CTRL, C_EN | C_MS | C_AUTO);
        mon_arm(1'b0, 1'b0);
        r0 = ss_rises;
        bus_write(A_TX, 8'hA5);
        wait_idle();
        check("R2 mosi byte", mon_q[0], 8'hA5);
        check("R7 period k=0", per_last, 2);
        check("R4 single select pulse", ss_rises - r0, 1);
        bus_read(A_RX, d);
        check("R2 loopback rx", d, 8'hA5);
    endtask

    task automatic t_continuous_k2();
        logic [7:0] d;
        int r0;
        bus_write(A_DIV, 8'h02);
        mon_arm(1'b0, 1'b0);
        r0 = ss_rises;
        bus_write(A_TX, 8'h3C);
        bus_write(A_TX, 8'hC3);
        bus_write(A_TX, 8'h0F);
        wait_idle();
        check("R4 one select pulse for three bytes", ss_rises - r0, 1);
        check("R7 period k=2", per_last, 8);
        check("R3 tx order 0", mon_q[0], 8'h3C);
        check("R3 tx order 1", mon_q[1], 8'hC3);
        check("R3 tx order 2", mon_q[2], 8'h0F);
        bus_read(A_RX, d); check("R3 rx order 0", d, 8'h3C);
        bus_read(A_RX, d); check("R3 rx order 1", d, 8'hC3);
        bus_read(A_RX, d); check("R3 rx order 2", d, 8'h0F);
    endtask

    task automatic t_modes();
        logic [7:0] d;
        logic [7:0] pat [4] = '{8'h00, 8'h81, 8'h6E, 8'hD2};
        for (int m = 1; m < 4; m++) begin
            bus_write(A_CTRL, C_EN | C_MS | C_AUTO | (m[1] ? C_POL : 8'h00) | (m[0] ? C_PHA : 8'h00));
            check("R6 idle clock level", sclk_o, m[1]);
            mon_arm(m[1], m[0]);
            bus_write(A_TX, pat[m]);
            wait_idle();
            check("R6 mosi byte in mode", mon_q[0], pat[m]);
            bus_read(A_RX, d);
            check("R6 rx byte in mode", d, pat[m]);
            check("R6 idle after byte", sclk_o, m[1]);
        end
        bus_write(A_CTRL, 8'h00);
    endtask

    task automatic t_overflow();
        logic [7:0] d;
        bus_write(A_TX, 8'h11);
        bus_write(A_TX, 8'h22);
        bus_write(A_TX, 8'h33);
        bus_write(A_TX, 8'h44);
        bus_write(A_TX, 8'h55);
        bus_read(A_STAT, d);
        check("R9 tx overflow and full", d & 8'h23, 8'h21);
        mon_arm(1'b0, 1'b0);
        bus_write(A_CTRL, C_EN | C_MS | C_AUTO);
        wait_idle();
        check("R8 irq on rx full", irq, 1);
        bus_write(A_TX, 8'h66);
        wait_idle();
        check("R2 fifth byte sent", mon_q[4], 8'h66);
        bus_read(A_STAT, d);
        check("R9 rx overflow and full", d & 8'h83, 8'h83);
        bus_read(A_RX, d); check("R3 rx 0", d, 8'h11);
        check("R8 irq drops", irq, 0);
        bus_read(A_RX, d); check("R3 rx 1", d, 8'h22);
        bus_read(A_RX, d); check("R3 rx 2", d, 8'h33);
        bus_read(A_RX, d); check("R9 dropped byte absent", d, 8'h44);
        bus_read(A_RX, d); check("R10 underflow repeats last", d, 8'h44);
        bus_read(A_STAT, d);
        check("R10 underflow bit", d[2], 1);
        bus_write(A_STAT, 8'h07);
        bus_read(A_STAT, d);
        check("R9 sticky bits cleared", d & 8'h07, 8'h00);
        bus_write(A_CTRL, 8'h00);
    endtask

    task automatic slave_byte(input logic [7:0] out, output logic [7:0] got, input bit sel);
        got = '0;
        ss_n_i = !sel;
        repeat (8) @(negedge clk);
        for (int i = 7; i >= 0; i--) begin
            mosi_i = out[i];
            repeat (8) @(negedge clk);
            got = {got[6:0], miso_o};
            sclk_i = 1'b1;
            repeat (8) @(negedge clk);
            sclk_i = 1'b0;
        end
        repeat (8) @(negedge clk);
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_slave();
        logic [7:0] d, got;
        bus_write(A_CTRL, C_EN | C_SS);
        bus_write(A_TX, 8'h96);
        repeat (4) @(negedge clk);
        slave_byte(8'h3C, got, 1'b1);
        check("R11 slave miso byte", got, 8'h96);
        bus_read(A_RX, d);
        check("R11 slave rx byte", d, 8'h3C);
        slave_byte(8'hFF, got, 1'b0);
        bus_read(A_STAT, d);
        check("R12 gated edges ignored", d[6], 1);
        bus_write(A_CTRL, C_EN);
        slave_byte(8'h5A, got, 1'b0);
        bus_read(A_RX, d);
        check("R12 select ignored when bit clear", d, 8'h5A);
        bus_write(A_CTRL, 8'h00);
    endtask

    task automatic t_irq_tx();
        bus_write(A_CTRL, C_IRQTX);
        check("R8 irq on tx empty", irq, 1);
        bus_write(A_TX, 8'h77);
        check("R8 irq clears with tx data", irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_manual_ss();
        t_single_k0();
        t_continuous_k2();
        t_modes();
        t_overflow();
        t_slave();
        t_irq_tx();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule